// File: doc/BRIEF.md
# Block-Erasable Byte Memory Command Controller

This block sits between a host bus and a byte-wide memory array that is split into equal blocks, 32 of them by default. The host writes command bytes and data through a single write strobe, and reads back either array contents or a status byte. Multi-write command sequences start internal operations:

- programming one byte;
- programming two consecutive bytes;
- erasing one block;
- erasing every block that is not locked.

A block erase can be paused so that other blocks can be read, and then continued.

Each block carries a lock bit. A global protect flag decides whether locked blocks refuse program and erase requests. A refused or malformed request never touches the array. It records error flags in the status byte and leaves the controller ready. The array is behavioural. Program and erase durations are parameter cycle counts, and the block size is a parameter: 16K-byte blocks need `BLK_AW = 14`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is ready (`rdy_o` = 1), reads return the status byte 0x80, every array byte is 0xFF, all lock bits are clear and protect is off.
- R2: Command 0x40 followed by a write of data D to address A programs A with D. `rdy_o` is low for exactly PROG_CYC cycles, starting in the cycle after the data write, and after that a read in array mode (command 0xFF) returns D at A.
- R3: Command 0xFB followed by two data writes programs the first byte at the first address and the second byte at that address plus one. The address given with the second data write is ignored, and the operation busies the controller for PROG_CYC cycles.
- R4: Command 0x20 followed by 0xD0 at an address erases the block selected by address bits [ADDR_W-1:BLK_AW] to 0xFF in ERASE_CYC busy cycles. Other blocks are left unchanged.
- R5: Command 0xA7 followed by 0xD0 erases every block whose lock bit is clear, in ERASE_CYC busy cycles. Locked blocks keep their data whatever the protect flag is.
- R6: Command 0x77 followed by 0xD0 sets the lock bit of the addressed block, and the bit stays set until reset. Command 0x57 turns protect on and 0x97 turns it off. With protect on, a program or erase aimed at a locked block leaves the array unchanged, sets status bit 1 together with bit 4 (program) or bit 5 (erase), and `rdy_o` stays high. With protect off, locked blocks can be programmed.
- R7: While an operation runs, every bus write other than an accepted suspend is ignored. Reads return the status byte, whose bit 7 is 0.
- R8: Command 0xB0 during a single-block erase suspends it: `rdy_o` rises, status bit 6 is set and the erase makes no progress. In this state:
  - after 0xFF, other blocks read their data and the suspended block reads 0xFF when SUSP_RD_ERASED = 1 (old data otherwise);
  - commands other than 0xFF, 0x70 and 0xD0 are ignored;
  - 0xD0 resumes the erase for its remaining cycles.
  0xB0 during a program or an erase-all is ignored.
- R9: The status byte is laid out as follows: bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 program error, bit 1 lock error, all other bits 0. Command 0x70 selects status reads and 0xFF selects array reads. Error bits stay set until command 0x50 clears them.
- R10: An unknown opcode, or a second write that is not 0xD0 after 0x20, 0xA7 or 0x77, sets status bits 5 and 4, switches to status reads, leaves the array unchanged and keeps `rdy_o` high.
- R11: `rdy_o` always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one command or data byte per cycle |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | 8 | Command or data byte |
| bus_rdata | output | 8 | Array byte or status byte, depending on the read mode |
| rdy_o | output | 1 | High when no operation is running |

## Verification
The bench builds the block with 16-byte blocks (BLK_AW = 4), which makes a 512-byte array. This keeps the erase-all sweep and the reference model's memory small. PROG_CYC = 3 and ERASE_CYC = 8 make the busy windows short enough to measure exactly, and leave room to place a suspend in the middle of an erase and count the cycles that remain after the resume. SUSP_RD_ERASED = 1 makes a read of the suspended block return a value that differs from its old data.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STAT   = 8'h70;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;
    localparam logic [7:0] OP_PROG      = 8'h40;
    localparam logic [7:0] OP_PROG2     = 8'hFB;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_ERASE_ALL = 8'hA7;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;
    localparam logic [7:0] OP_LOCK      = 8'h77;
    localparam logic [7:0] OP_PROT_ON   = 8'h57;
    localparam logic [7:0] OP_PROT_OFF  = 8'h97;

    typedef enum logic [2:0] {
        CS_IDLE, CS_PROG, CS_PRG2A, CS_PRG2B, CS_ERASE, CS_EALL, CS_LOCK
    } cmd_st_e;

    typedef enum logic [1:0] {AK_PROG, AK_BERASE, AK_EALL} akind_e;

    typedef struct packed {
        logic       ready;
        logic       susp;
        logic       erase_err;
        logic       write_err;
        logic [1:0] rsv_hi;
        logic       lock_err;
        logic       rsv_lo;
    } status_t;

endpackage

// File: rtl/fcc_locks.sv
module fcc_locks #(
    parameter int NBLK = 32,
    localparam int BW = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [BW-1:0]   set_idx,
    input  logic            prot_on,
    input  logic            prot_off,
    output logic [NBLK-1:0] lock_vec,
    output logic            prot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_vec <= '0;
            prot     <= 1'b0;
        end else begin
            if (set_en)   lock_vec[set_idx] <= 1'b1;
            if (prot_on)  prot <= 1'b1;
            if (prot_off) prot <= 1'b0;
        end
    end
endmodule

// File: rtl/fcc_array.sv
module fcc_array import fcc_pkg::*; #(
    parameter int AW = 11,
    parameter int BAW = 6,
    parameter int PROG_CYC = 4,
    parameter int ERASE_CYC = 16,
    parameter bit SUSP_RD_ERASED = 1'b1,
    localparam int NBLK = 1 << (AW - BAW),
    localparam int DEPTH = 1 << AW,
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
    localparam int CW = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  akind_e          kind,
    input  logic [AW-1:0]   op_addr,
    input  logic [7:0]      d0,
    input  logic [7:0]      d1,
    input  logic            two,
    input  logic [NBLK-1:0] emask,
    input  logic            hold,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic            busy,
    output logic            last
);
    logic [7:0]      mem [DEPTH];
    logic [CW-1:0]   cnt;
    akind_e          kind_q;
    logic [AW-1:0]   addr_q;
    logic [7:0]      d0_q, d1_q;
    logic            two_q;
    logic [NBLK-1:0] mask_q;

    function automatic logic [AW-BAW-1:0] blk_of(input logic [AW-1:0] a);
        return a[AW-1:BAW];
    endfunction

    assign last = busy && (cnt == '0) && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            kind_q <= AK_PROG;
            addr_q <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
            two_q  <= 1'b0;
            mask_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (go) begin
            busy   <= 1'b1;
            cnt    <= (kind == AK_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
            kind_q <= kind;
            addr_q <= op_addr;
            d0_q   <= d0;
            d1_q   <= d1;
            two_q  <= two;
            mask_q <= emask;
        end else if (busy && !hold) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                if (kind_q == AK_PROG) begin
                    mem[addr_q] <= d0_q;
                    if (two_q) mem[addr_q + AW'(1)] <= d1_q;
                end else begin
                    for (int i = 0; i < DEPTH; i++)
                        if (mask_q[blk_of(AW'(i))]) mem[i] <= 8'hFF;
                end
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    always_comb begin
        if (SUSP_RD_ERASED && hold && busy && mask_q[blk_of(rd_addr)])
            rd_data = 8'hFF;
        else
            rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/fcc_decode.sv
module fcc_decode import fcc_pkg::*; #(
    parameter int AW = 11,
    parameter int BAW = 6,
    localparam int NBLK = 1 << (AW - BAW),
    localparam int BW = AW - BAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [7:0]      bus_wdata,
    input  logic            arr_busy,
    input  logic            arr_last,
    input  logic [NBLK-1:0] lock_vec,
    input  logic            prot,
    output logic            op_go,
    output akind_e          op_kind,
    output logic [AW-1:0]   op_addr,
    output logic [7:0]      op_d0,
    output logic [7:0]      op_d1,
    output logic            op_two,
    output logic [NBLK-1:0] op_mask,
    output logic            lk_set,
    output logic [BW-1:0]   lk_idx,
    output logic            prot_on,
    output logic            prot_off,
    output logic            hold,
    output logic            show_arr,
    output status_t         sts
);
    cmd_st_e       st, st_n;
    logic          arr_n, susp_n, berase, berase_n;
    logic          ee, we, le, ee_n, we_n, le_n;
    logic [AW-1:0] a0;
    logic [7:0]    b0;
    logic          cap;

    function automatic logic guarded(input logic [AW-1:0] a, input logic [NBLK-1:0] lv,
                                     input logic pr);
        return pr && lv[a[AW-1:BAW]];
    endfunction

    assign lk_idx = bus_addr[AW-1:BAW];
    assign sts = '{ready: !(arr_busy && !hold), susp: hold, erase_err: ee, write_err: we,
                   rsv_hi: 2'b00, lock_err: le, rsv_lo: 1'b0};

    always_comb begin
        st_n = st; arr_n = show_arr; susp_n = hold; berase_n = berase;
        ee_n = ee; we_n = we; le_n = le;
        op_go = 1'b0; op_kind = AK_PROG; op_addr = bus_addr; op_d0 = bus_wdata;
        op_d1 = bus_wdata; op_two = 1'b0; op_mask = '0;
        lk_set = 1'b0; prot_on = 1'b0; prot_off = 1'b0; cap = 1'b0;
        if (bus_wr) begin
            if (arr_busy && !hold) begin
                if (bus_wdata == OP_SUSPEND && berase && !arr_last) begin
                    susp_n = 1'b1; arr_n = 1'b0;
                end
            end else if (hold) begin
                if (bus_wdata == OP_RD_ARRAY) arr_n = 1'b1;
                else if (bus_wdata == OP_RD_STAT) arr_n = 1'b0;
                else if (bus_wdata == OP_CONFIRM) begin susp_n = 1'b0; arr_n = 1'b0; end
            end else begin
                st_n = CS_IDLE;
                arr_n = 1'b0;
                case (st)
                    CS_IDLE: begin
                        arr_n = show_arr;
                        case (bus_wdata)
                            OP_RD_ARRAY:  arr_n = 1'b1;
                            OP_RD_STAT:   arr_n = 1'b0;
                            OP_CLR_STAT:  begin ee_n = 1'b0; we_n = 1'b0; le_n = 1'b0; end
                            OP_PROT_ON:   prot_on = 1'b1;
                            OP_PROT_OFF:  prot_off = 1'b1;
                            OP_PROG:      begin st_n = CS_PROG;  arr_n = 1'b0; end
                            OP_PROG2:     begin st_n = CS_PRG2A; arr_n = 1'b0; end
                            OP_ERASE:     begin st_n = CS_ERASE; arr_n = 1'b0; end
                            OP_ERASE_ALL: begin st_n = CS_EALL;  arr_n = 1'b0; end
                            OP_LOCK:      begin st_n = CS_LOCK;  arr_n = 1'b0; end
                            default:      begin ee_n = 1'b1; we_n = 1'b1; arr_n = 1'b0; end
                        endcase
                    end
                    CS_PROG: begin
                        if (guarded(bus_addr, lock_vec, prot)) begin le_n = 1'b1; we_n = 1'b1; end
                        else begin op_go = 1'b1; berase_n = 1'b0; end
                    end
                    CS_PRG2A: begin st_n = CS_PRG2B; cap = 1'b1; end
                    CS_PRG2B: begin
                        op_addr = a0; op_d0 = b0; op_two = 1'b1;
                        if (guarded(a0, lock_vec, prot) || guarded(a0 + AW'(1), lock_vec, prot)) begin
                            le_n = 1'b1; we_n = 1'b1;
                        end else begin op_go = 1'b1; berase_n = 1'b0; end
                    end
                    CS_ERASE: begin
                        if (bus_wdata != OP_CONFIRM) begin ee_n = 1'b1; we_n = 1'b1; end
                        else if (guarded(bus_addr, lock_vec, prot)) begin le_n = 1'b1; ee_n = 1'b1; end
                        else begin
                            op_go = 1'b1; op_kind = AK_BERASE; berase_n = 1'b1;
                            op_mask[bus_addr[AW-1:BAW]] = 1'b1;
                        end
                    end
                    CS_EALL: begin
                        if (bus_wdata != OP_CONFIRM) begin ee_n = 1'b1; we_n = 1'b1; end
                        else begin
                            op_go = 1'b1; op_kind = AK_EALL; berase_n = 1'b0; op_mask = ~lock_vec;
                        end
                    end
                    CS_LOCK: begin
                        if (bus_wdata != OP_CONFIRM) begin ee_n = 1'b1; we_n = 1'b1; end
                        else lk_set = 1'b1;
                    end
                    default: st_n = CS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= CS_IDLE; show_arr <= 1'b0; hold <= 1'b0; berase <= 1'b0;
            ee <= 1'b0; we <= 1'b0; le <= 1'b0; a0 <= '0; b0 <= '0;
        end else begin
            st <= st_n; show_arr <= arr_n; hold <= susp_n; berase <= berase_n;
            ee <= ee_n; we <= we_n; le <= le_n;
            if (cap) begin a0 <= bus_addr; b0 <= bus_wdata; end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import fcc_pkg::*; #(
    parameter int BLK_AW = 6,
    parameter int NBLK_LOG = 5,
    parameter int PROG_CYC = 4,
    parameter int ERASE_CYC = 16,
    parameter bit SUSP_RD_ERASED = 1'b1,
    localparam int ADDR_W = NBLK_LOG + BLK_AW,
    localparam int NBLK = 1 << NBLK_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              rdy_o
);
    logic              op_go, op_two, lk_set, prot_on, prot_off, hold, show_arr;
    logic              arr_busy, arr_last, prot;
    akind_e            op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_d0, op_d1, arr_rd;
    logic [NBLK-1:0]   op_mask, lock_vec;
    logic [NBLK_LOG-1:0] lk_idx;
    status_t           sts;

    fcc_decode #(.AW(ADDR_W), .BAW(BLK_AW)) u_dec (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .arr_busy(arr_busy), .arr_last(arr_last), .lock_vec(lock_vec), .prot(prot),
        .op_go(op_go), .op_kind(op_kind), .op_addr(op_addr), .op_d0(op_d0), .op_d1(op_d1),
        .op_two(op_two), .op_mask(op_mask), .lk_set(lk_set), .lk_idx(lk_idx),
        .prot_on(prot_on), .prot_off(prot_off), .hold(hold), .show_arr(show_arr), .sts(sts)
    );

    fcc_locks #(.NBLK(NBLK)) u_lck (
        .clk(clk), .rst(rst), .set_en(lk_set), .set_idx(lk_idx),
        .prot_on(prot_on), .prot_off(prot_off), .lock_vec(lock_vec), .prot(prot)
    );

    fcc_array #(.AW(ADDR_W), .BAW(BLK_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                .SUSP_RD_ERASED(SUSP_RD_ERASED)) u_arr (
        .clk(clk), .rst(rst), .go(op_go), .kind(op_kind), .op_addr(op_addr),
        .d0(op_d0), .d1(op_d1), .two(op_two), .emask(op_mask), .hold(hold),
        .rd_addr(bus_addr), .rd_data(arr_rd), .busy(arr_busy), .last(arr_last)
    );

    assign bus_rdata = show_arr ? arr_rd : sts;
    assign rdy_o     = sts.ready;
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk import fcc_pkg::*; #(
    parameter int NBLK = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic [7:0]      bus_wdata,
    input logic            rdy_o,
    input logic [NBLK-1:0] lock_vec,
    input logic            op_go,
    input logic            arr_busy,
    input status_t         sts
);
    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_o) |-> $past(bus_wr)); // R2
    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (($past(lock_vec) & ~lock_vec) == '0)); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        op_go |-> !arr_busy); // R7
    AST_SUSP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts.susp) |-> $past(bus_wr && bus_wdata == OP_SUSPEND)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($fell(sts.erase_err) || $fell(sts.write_err) || $fell(sts.lock_err))
        |-> $past(bus_wr && bus_wdata == OP_CLR_STAT)); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(sts.erase_err) || $rose(sts.write_err)) |-> $past(bus_wr)); // R10
endmodule

bind flash_cmd_ctrl fcc_chk #(.NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rdy_o(rdy_o),
    .lock_vec(lock_vec), .op_go(op_go), .arr_busy(arr_busy), .sts(sts)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int BAW = 4, NBL = 5, AW = 9, DEP = 512, NB = 32, PC = 3, EC = 8;

    logic          clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0, bus_rdata;
    logic          rdy_o;
    int            nchk = 0, nbad = 0;
    bit            live = 1'b0, done = 1'b0;
    string         cur = "R1";

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.BLK_AW(BAW), .NBLK_LOG(NBL), .PROG_CYC(PC), .ERASE_CYC(EC),
                     .SUSP_RD_ERASED(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdy_o(rdy_o));

    // ---------------- behavioural reference model ----------------
    logic [7:0] mm [DEP];
    bit [NB-1:0] mlk, mmask;
    bit mprot, mbusy, msusp, marr, mee, mwe, mle, mtwo, mberase;
    int mst, mcnt, mkind, maddr, ma0;
    logic [7:0] md0, md1, mb0;

    function automatic bit mready();
        return !(mbusy && !msusp);
    endfunction
    function automatic logic [7:0] mstatus();
        return {mready(), msusp, mee, mwe, 2'b00, mle, 1'b0};
    endfunction
    function automatic logic [7:0] mread(int a);
        if (!marr) return mstatus();
        if (msusp && mbusy && mmask[a >> BAW]) return 8'hFF;
        return mm[a];
    endfunction
    function automatic bit mguard(int a);
        return mprot && mlk[(a % DEP) >> BAW];
    endfunction

    task automatic mstart(int kind, int a, logic [7:0] x0, logic [7:0] x1, bit tw, bit [NB-1:0] mk);
        mbusy = 1; mkind = kind; maddr = a; md0 = x0; md1 = x1; mtwo = tw; mmask = mk;
        mcnt = (kind == 0) ? PC - 1 : EC - 1;
        mberase = (kind == 1);
    endtask

    task automatic mcmd(int a, logic [7:0] d, bit ob, bit os, bit ofin);
        if (ob && !os) begin
            if (d == 8'hB0 && mberase && !ofin) begin msusp = 1; marr = 0; end
        end else if (os) begin
            if (d == 8'hFF) marr = 1;
            else if (d == 8'h70) marr = 0;
            else if (d == 8'hD0) begin msusp = 0; marr = 0; end
        end else begin
            int s = mst;
            mst = 0;
            if (s != 0) marr = 0;
            case (s)
                0: case (d)
                    8'hFF: marr = 1;
                    8'h70: marr = 0;
                    8'h50: begin mee = 0; mwe = 0; mle = 0; end
                    8'h57: mprot = 1;
                    8'h97: mprot = 0;
                    8'h40: begin mst = 1; marr = 0; end
                    8'hFB: begin mst = 2; marr = 0; end
                    8'h20: begin mst = 4; marr = 0; end
                    8'hA7: begin mst = 5; marr = 0; end
                    8'h77: begin mst = 6; marr = 0; end
                    default: begin mee = 1; mwe = 1; marr = 0; end
                endcase
                1: if (mguard(a)) begin mle = 1; mwe = 1; end
                   else mstart(0, a, d, d, 0, '0);
                2: begin mst = 3; ma0 = a; mb0 = d; end
                3: if (mguard(ma0) || mguard(ma0 + 1)) begin mle = 1; mwe = 1; end
                   else mstart(0, ma0, mb0, d, 1, '0);
                4: if (d != 8'hD0) begin mee = 1; mwe = 1; end
                   else if (mguard(a)) begin mle = 1; mee = 1; end
                   else mstart(1, a, 0, 0, 0, NB'(1) << (a >> BAW));
                5: if (d != 8'hD0) begin mee = 1; mwe = 1; end
                   else mstart(2, a, 0, 0, 0, ~mlk);
                6: if (d != 8'hD0) begin mee = 1; mwe = 1; end
                   else mlk[a >> BAW] = 1;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEP; i++) mm[i] = 8'hFF;
            mlk = '0; mmask = '0; mprot = 0; mbusy = 0; msusp = 0; marr = 0;
            mee = 0; mwe = 0; mle = 0; mst = 0; mcnt = 0; mberase = 0;
        end else begin
            bit ob, os, ofin;
            ob = mbusy; os = msusp;
            ofin = mbusy && mcnt == 0 && !msusp;
            if (mbusy && !msusp) begin
                if (mcnt == 0) begin
                    mbusy = 0;
                    if (mkind == 0) begin
                        mm[maddr] = md0;
                        if (mtwo) mm[(maddr + 1) % DEP] = md1;
                    end else begin
                        for (int i = 0; i < DEP; i++) if (mmask[i >> BAW]) mm[i] = 8'hFF;
                    end
                end else mcnt--;
            end
            if (bus_wr) mcmd(int'(bus_addr), bus_wdata, ob, os, ofin);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            #1;
            chk({cur, " model rdata"}, bus_rdata, mread(int'(bus_addr)));
            chk({cur, " model ready"}, {7'b0, rdy_o}, {7'b0, mready()});
            chk("R11 ready equals status bit 7", {7'b0, rdy_o}, {7'b0, mstatus() >> 7});
        end
    end

    task automatic wr(int a, logic [7:0] d);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(int a, logic [7:0] exp, string req);
        bus_addr = AW'(a);
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        forever begin
            #1;
            if (rdy_o) break;
            n++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #240000;
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int n, pre;
        repeat (3) @(negedge clk);
        rst = 0;
        live = 1;
        cur = "R1";
        rd(0, 8'h80, "R1 status after reset");
        chk("R1 ready after reset", {7'b0, rdy_o}, 8'h01);
        wr(0, 8'hFF);
        rd(0, 8'hFF, "R1 array erased at reset");
        rd(9'h1FF, 8'hFF, "R1 array erased at reset");

        cur = "R2";
        wr(5, 8'h40); wr(5, 8'h3C);
        busy_len(n);
        chk("R2 program busy cycles", 8'(n), 8'(PC));
        rd(0, 8'h80, "R2 status after program");
        wr(0, 8'hFF);
        rd(5, 8'h3C, "R2 programmed byte");

        cur = "R3";
        wr(9'h20, 8'hFB); wr(9'h20, 8'hA1); wr(9'h1FF, 8'hB2);
        busy_len(n);
        chk("R3 two-byte busy cycles", 8'(n), 8'(PC));
        wr(0, 8'hFF);
        rd(9'h20, 8'hA1, "R3 first byte");
        rd(9'h21, 8'hB2, "R3 second byte at next address");
        rd(9'h1FF, 8'hFF, "R3 second-cycle address ignored");

        cur = "R7";
        wr(9'h30, 8'h40); wr(9'h30, 8'h11);
        wr(0, 8'hFF);
        rd(9'h30, 8'h00, "R7 status while busy, command ignored");
        busy_len(n);
        rd(9'h30, 8'h80, "R7 still status mode after ignored command");

        cur = "R4";
        wr(7, 8'h20); wr(7, 8'hD0);
        busy_len(n);
        chk("R4 erase busy cycles", 8'(n), 8'(EC));
        wr(0, 8'hFF);
        rd(5, 8'hFF, "R4 erased block");
        rd(9'h20, 8'hA1, "R4 other block kept");

        cur = "R10";
        wr(0, 8'h20); wr(0, 8'h33);
        rd(0, 8'hB0, "R10 bad confirm sets bits 5 and 4");
        chk("R10 ready kept", {7'b0, rdy_o}, 8'h01);
        wr(0, 8'h50);
        rd(0, 8'h80, "R9 clear status");
        wr(0, 8'h12);
        rd(0, 8'hB0, "R10 unknown opcode");
        wr(0, 8'h70);
        rd(0, 8'hB0, "R9 error bits sticky");
        wr(0, 8'h50);
        wr(0, 8'hFF);
        rd(9'h20, 8'hA1, "R10 array unchanged");

        cur = "R6";
        wr(9'h20, 8'h77); wr(9'h20, 8'hD0);
        wr(0, 8'h57);
        wr(9'h22, 8'h40); wr(9'h22, 8'h55);
        rd(0, 8'h92, "R6 locked program refused");
        chk("R6 ready after refusal", {7'b0, rdy_o}, 8'h01);
        wr(0, 8'h50);
        wr(9'h20, 8'h20); wr(9'h20, 8'hD0);
        rd(0, 8'hA2, "R6 locked erase refused");
        wr(0, 8'h50);
        wr(9'h1F, 8'hFB); wr(9'h1F, 8'h01); wr(0, 8'h02);
        rd(0, 8'h92, "R6 two-byte into locked block refused");
        wr(0, 8'h50);
        wr(0, 8'hFF);
        rd(9'h22, 8'hFF, "R6 locked byte unchanged");
        rd(9'h1F, 8'hFF, "R6 neighbour byte unchanged");

        cur = "R5";
        wr(0, 8'hA7); wr(0, 8'hD0);
        busy_len(n);
        chk("R5 erase-all busy cycles", 8'(n), 8'(EC));
        wr(0, 8'hFF);
        rd(9'h20, 8'hA1, "R5 locked block kept");
        rd(9'h30, 8'hFF, "R5 unlocked block erased");
        wr(0, 8'h97);
        wr(9'h22, 8'h40); wr(9'h22, 8'h66);
        busy_len(n);
        wr(0, 8'hFF);
        rd(9'h22, 8'h66, "R6 locked block writable with protect off");

        cur = "R8";
        wr(9'h40, 8'h40); wr(9'h40, 8'h77); busy_len(n);
        wr(9'h50, 8'h40); wr(9'h50, 8'h99); busy_len(n);
        wr(9'h40, 8'h20); wr(9'h40, 8'hD0);
        pre = 0;
        repeat (3) begin #1; if (!rdy_o) pre++; @(negedge clk); end
        wr(0, 8'hB0);
        rd(0, 8'hC0, "R8 suspended status");
        chk("R8 ready while suspended", {7'b0, rdy_o}, 8'h01);
        wr(0, 8'h40);
        rd(0, 8'hC0, "R8 other command ignored while suspended");
        wr(0, 8'hFF);
        rd(9'h50, 8'h99, "R8 read other block");
        rd(9'h40, 8'hFF, "R8 suspended block reads erased");
        wr(0, 8'hD0);
        busy_len(n);
        chk("R8 cycles before suspend", 8'(pre), 8'd3);
        chk("R8 remaining cycles after resume", 8'(n), 8'(EC - 4));
        wr(0, 8'hFF);
        rd(9'h40, 8'hFF, "R8 erase completed");
        rd(9'h50, 8'h99, "R8 other block kept");
        wr(9'h60, 8'h40); wr(9'h60, 8'h12);
        wr(0, 8'hB0);
        rd(0, 8'h00, "R8 suspend ignored during program");
        busy_len(n);
        wr(0, 8'hFF);
        rd(9'h60, 8'h12, "R8 program finished normally");

        repeat (2) @(negedge clk);
        live = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule